// File: doc/BRIEF.md
# Quad-Pumped Inverting Data Path Codec

This block carries a 64-bit payload over an active-low bus that moves four words per bus clock period. It runs on a beat clock at four times the bus clock. A free-running 2-bit beat index marks the position within the period, and index 0 is the first beat. The transmit side accepts four 64-bit words in the last beat slot of a period and drives them one word per beat during the next period. The 64 lines form four 16-bit groups. On every beat, each group decides for itself whether to invert, so that no group drives more than half of its lines electrically low. Each group has an active-low inversion flag that shows the decision. The transmitter also drives an active-low data-ready line and an active-low busy line.

The receive side is wired to the same bus lines inside the block. It samples each beat that data-ready marks valid and undoes the inversion of each group that is flagged. After the fourth beat it presents the four rebuilt words with a one-cycle valid pulse. The bus lines are also brought out, so a bus observer can watch the encoded traffic.

The transmitter has two states. TX_IDLE leaves every line released high. It moves to TX_SEND when a payload is accepted. TX_SEND stays in place when another payload is accepted in its last beat, and returns to TX_IDLE otherwise. The receiver also has two states. RX_IDLE moves to RX_FILL when data-ready is low on beat 0. RX_FILL returns to RX_IDLE after it captures beat 3.

Top module: `dbi_quad_codec`

## Requirements
- R1: Group g covers data bits 16g+15 down to 16g, and inversion flag g (bus_inv_n[g]) belongs to that group alone, for g = 0..3.
- R2: Data and flag lines are active low: a logical 1 is driven as 0. With no transfer in progress, every data and flag line is 1.
- R3: A group is inverted when 9 or more of its 16 logical bits are 1. With exactly 8 it is sent as is. No group ever drives more than 8 lines low on a beat.
- R4: The inversion decision is made separately for each group on each beat.
- R5: Payload word k occupies in_data bits 64k+63 down to 64k and is driven on beat k of the period that follows acceptance, with word 0 first.
- R6: in_ready is 1 only in the last beat of each period, once every 4 beat cycles. A payload is accepted when in_valid and in_ready are both 1 at a clock edge.
- R7: drdy_n and dbsy_n are 0 during exactly the four beats of each accepted payload. They stay 0 with no gap when payloads are accepted back to back.
- R8: out_data has the same layout as in_data and equals the accepted payload bit for bit.
- R9: out_valid is a single-cycle pulse in the cycle that immediately follows the fourth beat of a payload.
- R10: While rst_n is 0, drdy_n, dbsy_n and all bus lines are 1, and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, four times the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A payload is offered |
| in_data | input | 256 | Four 64-bit words; word k in bits 64k+63:64k |
| in_ready | output | 1 | Acceptance slot (last beat of a period) |
| bus_data_n | output | 64 | Encoded active-low data lines |
| bus_inv_n | output | 4 | Active-low inversion flags, one for each group |
| drdy_n | output | 1 | Active-low data-ready |
| dbsy_n | output | 1 | Active-low bus busy |
| out_valid | output | 1 | One-cycle pulse: decoded payload present |
| out_data | output | 256 | Decoded four-word payload |

## Verification
A beat counter that drifts would move in_ready off its four-cycle rhythm and put words on the wrong beats. The bus monitor would see this at once, on the first beat of the next payload. A wrong state in the transmitter would show as a busy or ready line that does not match the queue of expected beats, within one beat. A fault in the per-group decision would show on that same beat, either as a flag that disagrees with the threshold or as a group with nine or more lines low. A fault in the receiver would show at the next valid pulse, as a pulse that comes early or late, or as a decoded word that differs from the one sent.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_t;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_FILL = 1'b1
    } rx_state_t;
endpackage

// File: rtl/dbi_group_enc.sv
module dbi_group_enc #(
    parameter int GRP_W = 16
) (
    input  logic [GRP_W-1:0] grp_i,
    output logic [GRP_W-1:0] grp_o,
    output logic             inv_o
);
    localparam int CW = $clog2(GRP_W + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < GRP_W; i++) begin
            ones = ones + CW'(grp_i[i]);
        end
    end

    // invert when strictly more than half of the lines would be driven low
    assign inv_o = (ones > CW'(GRP_W / 2));
    assign grp_o = inv_o ? ~grp_i : grp_i;
endmodule

// File: rtl/dbi_tx.sv
module dbi_tx
    import dbi_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int GRP_W  = 16,
    parameter int BEATS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BEATS)-1:0]  beat_i,
    input  logic                      in_valid,
    input  logic [BEATS*WORD_W-1:0]   in_data,
    output logic                      in_ready,
    output logic [WORD_W-1:0]         bus_data_n,
    output logic [WORD_W/GRP_W-1:0]   bus_inv_n,
    output logic                      drdy_n,
    output logic                      dbsy_n
);
    localparam int NGRP = WORD_W / GRP_W;
    localparam int BW   = $clog2(BEATS);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    tx_state_t                 state_q, state_d;
    logic [BEATS*WORD_W-1:0]   payload_q;
    logic [WORD_W-1:0]         cur_word, enc_word;
    logic [NGRP-1:0]           enc_inv;
    logic                      accept;

    assign in_ready = (beat_i == LAST);
    assign accept   = in_valid && in_ready;
    assign cur_word = payload_q[beat_i*WORD_W +: WORD_W];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (accept) state_d = TX_SEND;
            TX_SEND: if (beat_i == LAST && !accept) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      payload_q <= '0;
        else if (accept) payload_q <= in_data;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        dbi_group_enc #(.GRP_W(GRP_W)) u_enc (
            .grp_i (cur_word[g*GRP_W +: GRP_W]),
            .grp_o (enc_word[g*GRP_W +: GRP_W]),
            .inv_o (enc_inv[g])
        );

        // R3: never more than half of a group's lines low
        a_r3_low_count: assert property (@(posedge clk) disable iff (!rst_n)
            !dbsy_n |-> ($countones(~bus_data_n[g*GRP_W +: GRP_W]) <= GRP_W / 2));
    end

    always_comb begin
        bus_data_n = '1;
        bus_inv_n  = '1;
        drdy_n     = 1'b1;
        dbsy_n     = 1'b1;
        unique case (state_q)
            TX_IDLE: ;
            TX_SEND: begin
                drdy_n     = 1'b0;
                dbsy_n     = 1'b0;
                bus_data_n = ~enc_word;
                bus_inv_n  = ~enc_inv;
            end
        endcase
    end

    a_r7_accept_drives: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!drdy_n && !dbsy_n));

    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        dbsy_n |-> ((&bus_data_n) && (&bus_inv_n)));
endmodule

// File: rtl/dbi_rx.sv
module dbi_rx
    import dbi_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int GRP_W  = 16,
    parameter int BEATS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BEATS)-1:0]  beat_i,
    input  logic [WORD_W-1:0]         bus_data_n,
    input  logic [WORD_W/GRP_W-1:0]   bus_inv_n,
    input  logic                      drdy_n,
    output logic                      out_valid,
    output logic [BEATS*WORD_W-1:0]   out_data
);
    localparam int NGRP = WORD_W / GRP_W;
    localparam int BW   = $clog2(BEATS);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    rx_state_t               state_q, state_d;
    logic [BEATS*WORD_W-1:0] buf_q;
    logic [WORD_W-1:0]       dec_word;
    logic                    capture, finish, valid_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_dec
        assign dec_word[g*GRP_W +: GRP_W] =
            bus_inv_n[g] ? ~bus_data_n[g*GRP_W +: GRP_W] : bus_data_n[g*GRP_W +: GRP_W];
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            RX_IDLE: if (!drdy_n && beat_i == '0) begin
                capture = 1'b1;
                state_d = RX_FILL;
            end
            RX_FILL: if (!drdy_n) begin
                capture = 1'b1;
                if (beat_i == LAST) begin
                    finish  = 1'b1;
                    state_d = RX_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= finish;
            if (capture) buf_q[beat_i*WORD_W +: WORD_W] <= dec_word;
        end
    end

    assign out_valid = valid_q;
    assign out_data  = buf_q;

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r8_valid_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(!drdy_n));
endmodule

// File: rtl/dbi_quad_codec.sv
module dbi_quad_codec #(
    parameter int WORD_W = 64,
    parameter int GRP_W  = 16,
    parameter int BEATS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [BEATS*WORD_W-1:0]  in_data,
    output logic                     in_ready,
    output logic [WORD_W-1:0]        bus_data_n,
    output logic [WORD_W/GRP_W-1:0]  bus_inv_n,
    output logic                     drdy_n,
    output logic                     dbsy_n,
    output logic                     out_valid,
    output logic [BEATS*WORD_W-1:0]  out_data
);
    localparam int BW = $clog2(BEATS);

    logic [BW-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_q + 1'b1;
    end

    dbi_tx #(.WORD_W(WORD_W), .GRP_W(GRP_W), .BEATS(BEATS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_i     (beat_q),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .bus_data_n (bus_data_n),
        .bus_inv_n  (bus_inv_n),
        .drdy_n     (drdy_n),
        .dbsy_n     (dbsy_n)
    );

    dbi_rx #(.WORD_W(WORD_W), .GRP_W(GRP_W), .BEATS(BEATS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_i     (beat_q),
        .bus_data_n (bus_data_n),
        .bus_inv_n  (bus_inv_n),
        .drdy_n     (drdy_n),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    // R6: acceptance slot never lasts two cycles
    a_r6_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);
endmodule

// File: tb/dbi_quad_codec_bench.sv
module dbi_quad_codec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] in_data = '0;
    logic         in_ready;
    logic [63:0]  bus_data_n;
    logic [3:0]   bus_inv_n;
    logic         drdy_n, dbsy_n, out_valid;
    logic [255:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [255:0] pay_q[$];
    logic [63:0]  beat_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbi_quad_codec u_dbi_quad_codec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .bus_data_n(bus_data_n), .bus_inv_n(bus_inv_n),
        .drdy_n(drdy_n), .dbsy_n(dbsy_n), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [255:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        pay_q.push_back(d);
        for (int k = 0; k < 4; k++) beat_q.push_back(d[k*64 +: 64]);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    bit pend_v = 1'b0;
    int beat_cnt = 0;
    int cyc = 0;
    int last_rdy = -1;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            // R6: ready every fourth cycle
            if (in_ready) begin
                if (last_rdy >= 0)
                    chk(cyc - last_rdy == 4, "R6", "ready spacing", 256'(cyc - last_rdy), 256'd4);
                last_rdy = cyc;
            end
            // R9: pulse right after the fourth beat, one cycle only
            chk(out_valid == pend_v, "R9", "out_valid timing", 256'(out_valid), 256'(pend_v));
            if (out_valid && pay_q.size() > 0) begin
                logic [255:0] e;
                e = pay_q.pop_front();
                chk(out_data == e, "R8", "decoded payload", out_data, e);
            end
            // R7: busy/ready track pending beats
            chk(!drdy_n == (beat_q.size() > 0), "R7", "drdy_n vs pending beats",
                256'(drdy_n), 256'(beat_q.size() == 0));
            chk(dbsy_n == drdy_n, "R7", "dbsy_n follows drdy_n", 256'(dbsy_n), 256'(drdy_n));
            pend_v = 1'b0;
            if (!drdy_n && beat_q.size() > 0) begin
                logic [63:0] w;
                w = beat_q.pop_front();
                beat_cnt++;
                if (beat_cnt % 4 == 0) pend_v = 1'b1;
                for (int g = 0; g < 4; g++) begin
                    logic [15:0] t, seen;
                    bit ei;
                    t    = w[g*16 +: 16];
                    ei   = ($countones(t) >= 9);
                    seen = ~bus_data_n[g*16 +: 16];
                    // R1 R3 R4: flag for this group and beat
                    chk(bus_inv_n[g] == !ei, "R3", "inversion flag",
                        256'(bus_inv_n[g]), 256'(!ei));
                    // R2 R5: active-low levels of the right word
                    chk(seen == (ei ? ~t : t), "R5", "bus group level",
                        256'(seen), 256'(ei ? ~t : t));
                    chk($countones(seen) <= 8, "R3", "lines low in group",
                        256'($countones(seen)), 256'd8);
                end
            end else if (drdy_n) begin
                // R2: released lines idle high
                chk((&bus_data_n) && (&bus_inv_n), "R2", "idle lines high",
                    256'({bus_inv_n, bus_data_n}), {188'd0, 68'hF_FFFF_FFFF_FFFF_FFFF});
            end
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WDOG_LIMIT && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", wd, WDOG_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] rep(input logic [15:0] v);
        return {v, v, v, v};
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(drdy_n && dbsy_n, "R10", "strobes in reset", 256'({drdy_n, dbsy_n}), 256'd3);
        chk(!out_valid, "R10", "out_valid in reset", 256'(out_valid), 256'd0);
        chk((&bus_data_n) && (&bus_inv_n), "R10", "bus lines in reset",
            256'({bus_inv_n, bus_data_n}), {188'd0, 68'hF_FFFF_FFFF_FFFF_FFFF});
        rst_n = 1'b1;
        idle(3);
        // corner patterns: zeros, ones, exactly 8, exactly 9 (R3)
        send({rep(16'h0000), rep(16'hFFFF), rep(16'h00FF), rep(16'h01FF)});
        idle(2);
        // R4: mixed decisions per group and per beat
        send({{16'h01FF, 16'h0000, 16'hFFFF, 16'h00FF},
              {16'h0000, 16'h80FF, 16'h7FFF, 16'h0001},
              {16'hFF00, 16'hFF80, 16'h0F0F, 16'hFFFE},
              {16'h1234, 16'hFFFF, 16'h0000, 16'hF0F1}});
        // R1: one group at a time heavily loaded, back to back (R7)
        for (int g = 0; g < 4; g++) begin
            logic [63:0] w;
            w = '0;
            w[g*16 +: 16] = 16'hFFFF;
            send({w, ~w, w, 64'h0});
        end
        idle(5);
        // random traffic with random gaps
        for (int n = 0; n < 200; n++) begin
            logic [255:0] d;
            for (int k = 0; k < 8; k++) d[k*32 +: 32] = $urandom;
            if (n % 3 == 0) for (int k = 0; k < 16; k++) if ($urandom_range(1, 0) == 1)
                d[k*16 +: 16] = ($urandom_range(1, 0) == 1) ? 16'hFFFF : 16'h0000;
            send(d);
            if ($urandom_range(3, 0) == 0) idle($urandom_range(6, 1));
        end
        idle(12);
        chk(pay_q.size() == 0 && beat_q.size() == 0, "R8", "all payloads delivered",
            256'(pay_q.size()), 256'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule